// File: doc/BRIEF.md
# No-Turnaround Synchronous SRAM Core

This block is a single-port synchronous static RAM. Its data bus can switch between reads and writes on every cycle with no idle cycle in between. It samples a command on each rising clock edge. Write data is supplied later than its address: one cycle later in flow-through mode, two cycles later in pipelined mode. Because of that delay, the data-bus slot of a write never collides with the slot of a neighbouring read. The tri-state data pin is split into `din`, `dout` and a drive qualifier `dout_en`.

A static `pipe_en` pin selects the read path:
- In pipelined mode, read data passes through an output register. Bursts follow a 3-1-1-1 cadence.
- In flow-through mode, read data leaves the array straight after the access edge. Bursts follow a 2-1-1-1 cadence.

A load cycle starts a burst. Later advance cycles step the two low address bits in linear or interleaved order, chosen by `burst_ilv`. Writes are masked per 9-bit byte. If a read hits an address whose write data is still in flight, it returns that data merged under its byte mask.

Top module: `nbt_sram`

## Requirements
- R1: Commands are sampled at the rising edge of `clk`. The device is selected only when `ce1`=1, `ce2`=1 and `ce3_n`=0. A cycle with `adv_ld`=0 while not selected is a deselect: no access takes place and its read slot leaves `dout_en`=0.
- R2: With `pipe_en`=0, a read captured at edge t drives `dout` and raises `dout_en` in the cycle that follows edge t.
- R3: With `pipe_en`=1, a read captured at edge t drives `dout` and raises `dout_en` in the cycle that follows edge t+1.
- R4: Write data for a write captured at edge t is sampled from `din` at edge t+1 with `pipe_en`=0, and at edge t+2 with `pipe_en`=1.
- R5: Reads and writes may alternate on consecutive cycles with no deselect cycles. Every read still returns the data of all writes issued before it, and `dout_en` stays low in write slots.
- R6: `oe_n`=1 forces `dout_en` low at once, without waiting for a clock edge. Clearing `oe_n` during a read slot restores `dout_en`.
- R7: `bw_n[i]`=0 writes byte i, which is bits 9i+8..9i of the word. A byte whose `bw_n` bit is 1 keeps its old value. `bw_n`=all ones writes nothing.
- R8: With `burst_ilv`=0, beat k of a burst (k=0 is the load) uses low address bits (start+k) mod 4. The upper address bits stay those of the load.
- R9: With `burst_ilv`=1, beat k uses low address bits start XOR (k mod 4). The upper bits are unchanged.
- R10: An advance cycle (`adv_ld`=1) continues the active burst with the read/write type of its load. It ignores `we` and the chip enables, but takes `bw_n` afresh. An advance with no active burst, after reset or after a deselect, performs no access.
- R11: A read of an address whose write data is still pending returns the pending bytes merged with the stored word, according to that write's byte enables.
- R12: After reset `dout_en` is 0 and no burst is active. A deselect following a write does not cancel that write: its data still lands and is returned by a later read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| pipe_en | input | 1 | Static mode: 1 pipelined, 0 flow-through |
| burst_ilv | input | 1 | Static burst order: 0 linear, 1 interleaved |
| ce1 | input | 1 | Chip enable, active high |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| adv_ld | input | 1 | 0 loads a new address, 1 advances the burst |
| we | input | 1 | Access type on load: 1 write, 0 read |
| bw_n | input | 2 | Active-low byte write enables |
| addr | input | 10 | Word address, sampled on load |
| din | input | 18 | Late write data |
| oe_n | input | 1 | Asynchronous active-low output enable |
| dout | output | 18 | Read data |
| dout_en | output | 1 | High when `dout` should drive the bus |

## Verification
The bench goes after the following cases:
- **Read right after a write to the same word, under a partial byte mask.** A design without the pending-data bypass would return the stale word in pipelined mode.
- **Five-beat bursts that wrap, in both orders, with chip enables and `we` toggled during advances.** This exposes a sequencer that uses the wrong order, carries into the upper bits, or re-samples the access type.
- **Write, deselect, deselect, read.** This catches a design that drops captured writes on deselect.
- **Alternating read/write streams in both modes.** These catch an off-by-one in the late-write delay. Such a design would store the wrong `din` slot, and data would drift by a cycle.
- **Mid-cycle toggling of `oe_n`.** A design that samples output enable on the clock would leave `dout_en` high.

// File: rtl/nbt_sram_pkg.sv
package nbt_sram_pkg;

  localparam int BEAT_W = 2;

  typedef enum logic {
    ORDER_LINEAR      = 1'b0,
    ORDER_INTERLEAVED = 1'b1
  } burst_order_e;

  // Low address bits of a burst beat from its start value and beat count.
  function automatic logic [BEAT_W-1:0] beat_low(
    input logic [BEAT_W-1:0] start,
    input logic [BEAT_W-1:0] beat,
    input burst_order_e      order
  );
    logic [BEAT_W-1:0] res;
    if (order == ORDER_INTERLEAVED) res = start ^ beat;
    else                            res = start + beat;
    return res;
  endfunction

endpackage

// File: rtl/nbt_burst_seq.sv
module nbt_burst_seq
  import nbt_sram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int NBYTES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              adv_ld,
  input  logic              we,
  input  logic [NBYTES-1:0] bw_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              burst_ilv,
  output logic              acc_vld,
  output logic              acc_wr,
  output logic              acc_adv,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [NBYTES-1:0] acc_bw_n
);

  localparam int HI_W = ADDR_W - BEAT_W;

  logic              b_act, b_act_n;
  logic              b_wr, b_wr_n;
  logic [HI_W-1:0]   b_hi, b_hi_n;
  logic [BEAT_W-1:0] b_lo, b_lo_n;
  logic [BEAT_W-1:0] b_cnt, b_cnt_n, cnt_inc;

  logic              acc_vld_n, acc_wr_n, acc_adv_n;
  logic [ADDR_W-1:0] acc_addr_n;
  logic [NBYTES-1:0] acc_bw_n_n;

  logic do_load, do_desel, do_adv;
  burst_order_e order;

  always_comb begin
    order    = burst_order_e'(burst_ilv);
    do_load  = ~adv_ld & sel;
    do_desel = ~adv_ld & ~sel;
    do_adv   = adv_ld & b_act;
    cnt_inc  = b_cnt + 2'd1;

    b_act_n  = b_act;
    b_wr_n   = b_wr;
    b_hi_n   = b_hi;
    b_lo_n   = b_lo;
    b_cnt_n  = b_cnt;

    acc_vld_n  = 1'b0;
    acc_wr_n   = 1'b0;
    acc_adv_n  = 1'b0;
    acc_addr_n = acc_addr;
    acc_bw_n_n = '1;

    if (do_load) begin
      b_act_n    = 1'b1;
      b_wr_n     = we;
      b_hi_n     = addr[ADDR_W-1:BEAT_W];
      b_lo_n     = addr[BEAT_W-1:0];
      b_cnt_n    = '0;
      acc_vld_n  = 1'b1;
      acc_wr_n   = we;
      acc_addr_n = addr;
      acc_bw_n_n = bw_n;
    end else if (do_desel) begin
      b_act_n    = 1'b0;
    end else if (do_adv) begin
      b_cnt_n    = cnt_inc;
      acc_vld_n  = 1'b1;
      acc_wr_n   = b_wr;
      acc_adv_n  = 1'b1;
      acc_addr_n = {b_hi, beat_low(b_lo, cnt_inc, order)};
      acc_bw_n_n = bw_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_act    <= 1'b0;
      b_wr     <= 1'b0;
      b_hi     <= '0;
      b_lo     <= '0;
      b_cnt    <= '0;
      acc_vld  <= 1'b0;
      acc_wr   <= 1'b0;
      acc_adv  <= 1'b0;
      acc_addr <= '0;
      acc_bw_n <= '1;
    end else begin
      b_act    <= b_act_n;
      b_wr     <= b_wr_n;
      b_hi     <= b_hi_n;
      b_lo     <= b_lo_n;
      b_cnt    <= b_cnt_n;
      acc_vld  <= acc_vld_n;
      acc_wr   <= acc_wr_n;
      acc_adv  <= acc_adv_n;
      acc_addr <= acc_addr_n;
      acc_bw_n <= acc_bw_n_n;
    end
  end

  AST_DESEL_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_ld && !sel) |=> !acc_vld); // R1

  AST_BEAT_KEEPS_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && acc_adv) |-> (acc_addr[ADDR_W-1:BEAT_W] == $past(acc_addr[ADDR_W-1:BEAT_W]))); // R8

  AST_BEAT_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    acc_adv |-> (b_cnt == BEAT_W'($past(b_cnt) + 2'd1))); // R10

endmodule

// File: rtl/nbt_late_write.sv
module nbt_late_write #(
  parameter int ADDR_W = 10,
  parameter int NBYTES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pipe_en,
  input  logic              acc_vld,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [NBYTES-1:0] acc_bw_n,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [NBYTES-1:0] wr_be
);

  logic              s2_vld, s2_vld_n;
  logic [ADDR_W-1:0] s2_addr, s2_addr_n;
  logic [NBYTES-1:0] s2_be, s2_be_n;

  always_comb begin
    s2_vld_n  = acc_vld & acc_wr;
    s2_addr_n = s2_vld_n ? acc_addr : s2_addr;
    s2_be_n   = s2_vld_n ? ~acc_bw_n : s2_be;
    // Flow-through commits the first-stage write; pipelined commits one stage later.
    if (pipe_en) begin
      wr_en   = s2_vld;
      wr_addr = s2_addr;
      wr_be   = s2_be;
    end else begin
      wr_en   = acc_vld & acc_wr;
      wr_addr = acc_addr;
      wr_be   = ~acc_bw_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_vld  <= 1'b0;
      s2_addr <= '0;
      s2_be   <= '0;
    end else begin
      s2_vld  <= s2_vld_n;
      s2_addr <= s2_addr_n;
      s2_be   <= s2_be_n;
    end
  end

  AST_PIPE_WRITE_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_en && wr_en) |-> $past(acc_vld && acc_wr)); // R4

  AST_PIPE_WRITE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_en && wr_en) |-> (wr_addr == $past(acc_addr))); // R4

endmodule

// File: rtl/nbt_sram_array.sv
module nbt_sram_array #(
  parameter int ADDR_W = 10,
  parameter int BYTE_W = 9,
  parameter int NBYTES = 2,
  localparam int DATA_W = BYTE_W * NBYTES,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [NBYTES-1:0] wr_be,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  for (genvar b = 0; b < NBYTES; b++) begin : g_bank
    logic [BYTE_W-1:0] bank [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en && wr_be[b]) bank[wr_addr] <= wr_data[b*BYTE_W +: BYTE_W];
    end

    assign rd_data[b*BYTE_W +: BYTE_W] = bank[rd_addr];
  end

endmodule

// File: rtl/nbt_sram_out.sv
module nbt_sram_out #(
  parameter int ADDR_W = 10,
  parameter int BYTE_W = 9,
  parameter int NBYTES = 2,
  localparam int DATA_W = BYTE_W * NBYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pipe_en,
  input  logic              oe_n,
  input  logic              rd_vld,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_word,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [NBYTES-1:0] wr_be,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);

  logic              hit;
  logic [DATA_W-1:0] merged;
  logic              q_vld, q_vld_n;
  logic [DATA_W-1:0] q_data, q_data_n;
  logic              drive_vld;

  assign hit = wr_en && (wr_addr == rd_addr);

  // Pending write bytes override the stored word.
  for (genvar b = 0; b < NBYTES; b++) begin : g_merge
    assign merged[b*BYTE_W +: BYTE_W] = (hit && wr_be[b]) ? wr_data[b*BYTE_W +: BYTE_W]
                                                          : rd_word[b*BYTE_W +: BYTE_W];
  end

  always_comb begin
    q_vld_n  = rd_vld;
    q_data_n = rd_vld ? merged : q_data;
    if (pipe_en) begin
      dout      = q_data;
      drive_vld = q_vld;
    end else begin
      dout      = merged;
      drive_vld = rd_vld;
    end
    dout_en = drive_vld & ~oe_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_vld  <= 1'b0;
      q_data <= '0;
    end else begin
      q_vld  <= q_vld_n;
      q_data <= q_data_n;
    end
  end

  AST_PIPE_HOLDS_ARRAY_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_en && rd_vld && !hit) |=> (q_data == $past(rd_word))); // R3

endmodule

// File: rtl/nbt_sram.sv
module nbt_sram #(
  parameter int ADDR_W = 10,
  parameter int BYTE_W = 9,
  parameter int NBYTES = 2,
  localparam int DATA_W = BYTE_W * NBYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pipe_en,
  input  logic              burst_ilv,
  input  logic              ce1,
  input  logic              ce2,
  input  logic              ce3_n,
  input  logic              adv_ld,
  input  logic              we,
  input  logic [NBYTES-1:0] bw_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              oe_n,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);

  logic              sel;
  logic              acc_vld, acc_wr, acc_adv;
  logic [ADDR_W-1:0] acc_addr;
  logic [NBYTES-1:0] acc_bw_n;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [NBYTES-1:0] wr_be;
  logic [DATA_W-1:0] rd_word;
  logic              rd_vld;

  assign sel    = ce1 & ce2 & ~ce3_n;
  assign rd_vld = acc_vld & ~acc_wr;

  nbt_burst_seq #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) seq_i (
    .clk(clk), .rst_n(rst_n), .sel(sel), .adv_ld(adv_ld), .we(we),
    .bw_n(bw_n), .addr(addr), .burst_ilv(burst_ilv),
    .acc_vld(acc_vld), .acc_wr(acc_wr), .acc_adv(acc_adv),
    .acc_addr(acc_addr), .acc_bw_n(acc_bw_n)
  );

  nbt_late_write #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) lw_i (
    .clk(clk), .rst_n(rst_n), .pipe_en(pipe_en),
    .acc_vld(acc_vld), .acc_wr(acc_wr), .acc_addr(acc_addr), .acc_bw_n(acc_bw_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be)
  );

  nbt_sram_array #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .NBYTES(NBYTES)) mem_i (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be), .wr_data(din),
    .rd_addr(acc_addr), .rd_data(rd_word)
  );

  nbt_sram_out #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .NBYTES(NBYTES)) out_i (
    .clk(clk), .rst_n(rst_n), .pipe_en(pipe_en), .oe_n(oe_n),
    .rd_vld(rd_vld), .rd_addr(acc_addr), .rd_word(rd_word),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be), .wr_data(din),
    .dout(dout), .dout_en(dout_en)
  );

endmodule

// File: tb/nbt_sram_tb_top.sv
module nbt_sram_tb_top;

  localparam int AW   = 10;
  localparam int BW   = 9;
  localparam int NB   = 2;
  localparam int DW   = BW * NB;
  localparam int NCYC = 4096;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          pipe_en, burst_ilv;
  logic          ce1, ce2, ce3_n, adv_ld, we, oe_n;
  logic [NB-1:0] bw_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] din;
  logic [DW-1:0] dout;
  logic          dout_en;

  nbt_sram dut_i (
    .clk(clk), .rst_n(rst_n), .pipe_en(pipe_en), .burst_ilv(burst_ilv),
    .ce1(ce1), .ce2(ce2), .ce3_n(ce3_n), .adv_ld(adv_ld), .we(we),
    .bw_n(bw_n), .addr(addr), .din(din), .oe_n(oe_n),
    .dout(dout), .dout_en(dout_en)
  );

  always #4 clk = ~clk;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  logic [DW-1:0] ref_mem [1 << AW];
  logic          c_vld   [NCYC];
  logic          c_wr    [NCYC];
  logic [AW-1:0] c_addr  [NCYC];
  logic [DW-1:0] c_wdata [NCYC];
  logic [DW-1:0] c_exp   [NCYC];
  string         c_tag   [NCYC];

  int cyc = 0;
  int ps  = 0;
  int lat = 1;
  bit pm, il, probe;
  logic cur_oe_n;
  logic m_act, m_wr;
  logic [AW-1:0] m_base;
  logic [1:0] m_cnt;
  logic [AW-1:0] last_a;

  function automatic logic [AW-1:0] rand_addr();
    logic [5:0] hi;
    hi = 6'(($urandom % 4) * 21);
    return {hi, 4'($urandom)};
  endfunction

  function automatic logic [1:0] exp_low(logic [1:0] s, logic [1:0] k, bit ord);
    return ord ? (s ^ k) : 2'(s + k);
  endfunction

  task automatic report(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    fails++;
    $display("FAIL %s %s: actual %h expected %h (t=%0t)", req, what, act, exp, $time);
  endtask

  task automatic check_slot(int t);
    logic exp_en;
    string tg;
    exp_en = c_vld[t] && !c_wr[t] && !cur_oe_n;
    tg = cur_oe_n ? "R6" : c_tag[t];
    vectors++;
    if (dout_en !== exp_en) report(tg, "dout_en", DW'(dout_en), DW'(exp_en));
    else if (exp_en) begin
      vectors++;
      if (dout !== c_exp[t]) report(tg, "dout", dout, c_exp[t]);
      if (probe && ($urandom % 4 == 0)) begin
        oe_n = 1'b1; #1;
        vectors++;
        if (dout_en !== 1'b0) report("R6", "dout_en with oe_n high", DW'(dout_en), '0);
        oe_n = 1'b0; #1;
        vectors++;
        if (dout_en !== 1'b1) report("R6", "dout_en after oe_n low", DW'(dout_en), DW'(1));
      end
    end
  endtask

  // One command cycle: check the slot due now, model the command, drive pins.
  task automatic issue(bit adv, bit wr, logic [AW-1:0] a, logic [NB-1:0] bwn,
                       bit sel, bit oe, string ftag);
    int u;
    int k;
    logic [DW-1:0] wd;
    string tg;
    u = cyc;
    if (u - lat >= ps) check_slot(u - lat);

    c_vld[u] = 1'b0; c_wr[u] = 1'b0; c_addr[u] = a; tg = "R1";
    if (!adv) begin
      if (sel) begin
        m_act = 1'b1; m_wr = wr; m_base = a; m_cnt = 2'd0;
        c_vld[u] = 1'b1; c_wr[u] = wr; c_addr[u] = a;
      end else m_act = 1'b0;
    end else if (m_act) begin
      m_cnt = m_cnt + 2'd1;
      c_vld[u] = 1'b1; c_wr[u] = m_wr;
      c_addr[u] = {m_base[AW-1:2], exp_low(m_base[1:0], m_cnt, il)};
    end else tg = "R10";

    if (c_vld[u] && c_wr[u]) begin
      wd = DW'($urandom);
      c_wdata[u] = wd;
      for (int b = 0; b < NB; b++)
        if (!bwn[b]) ref_mem[c_addr[u]][b*BW +: BW] = wd[b*BW +: BW];
      tg = "R5";
    end else if (c_vld[u]) begin
      c_exp[u] = ref_mem[c_addr[u]];
      if (adv) tg = il ? "R9" : "R8";
      else tg = pm ? "R3" : "R2";
      for (int d = 1; d <= 2; d++)
        if (u - d >= ps && c_vld[u-d] && c_wr[u-d])
          tg = (c_addr[u-d] == c_addr[u]) ? "R11" : "R4";
    end
    c_tag[u] = (ftag != "") ? ftag : tg;

    adv_ld = adv; we = wr; addr = a; bw_n = bwn; oe_n = oe; cur_oe_n = oe;
    if (sel) begin ce1 = 1'b1; ce2 = 1'b1; ce3_n = 1'b0; end
    else begin
      k = $urandom % 3;
      ce1 = (k != 0); ce2 = (k != 1); ce3_n = (k == 2);
    end
    if (u - lat >= ps && c_vld[u-lat] && c_wr[u-lat]) din = c_wdata[u-lat];
    else din = DW'($urandom);
    cyc++;
    @(negedge clk);
  endtask

  task automatic start_phase(bit p, bit i);
    @(negedge clk);
    rst_n = 1'b0; pipe_en = p; burst_ilv = i; pm = p; il = i; lat = p ? 2 : 1;
    adv_ld = 1'b0; ce1 = 1'b0; ce2 = 1'b0; ce3_n = 1'b1; oe_n = 1'b0; cur_oe_n = 1'b0;
    we = 1'b0; bw_n = '1; addr = '0; din = '0;
    @(negedge clk); @(negedge clk);
    vectors++;
    if (dout_en !== 1'b0) report("R12", "dout_en in reset", DW'(dout_en), '0);
    rst_n = 1'b1;
    @(negedge clk);
    vectors++;
    if (dout_en !== 1'b0) report("R12", "dout_en after reset", DW'(dout_en), '0);
    m_act = 1'b0; m_cnt = 2'd0; m_wr = 1'b0; m_base = '0;
    ps = cyc;
    probe = 1'b0;
  endtask

  task automatic run_phase(bit p, bit i, bit prefill);
    logic [AW-1:0] a, b;
    start_phase(p, i);
    issue(1, 0, rand_addr(), 2'b00, 1, 0, "R10");       // advance with no burst
    if (prefill)
      for (int g = 0; g < 16; g++) begin
        issue(0, 1, {6'((g / 4) * 21), 2'(g % 4), 2'b00}, 2'b00, 1, 0, "");
        for (int k = 0; k < 3; k++) issue(1, 0, '0, 2'b00, 1, 0, "");
      end
    for (int k = 0; k < 8; k++) begin                    // R5 alternating stream
      a = rand_addr(); b = (k % 2) ? a : rand_addr();
      issue(0, 0, a, 2'b11, 1, 0, "R5");
      issue(0, 1, b, 2'b00, 1, 0, "R5");
    end
    issue(0, 0, b, 2'b11, 1, 0, "R5");
    a = rand_addr();                                     // R12 write survives deselect
    issue(0, 1, a, 2'b00, 1, 0, "");
    issue(0, 0, '0, 2'b00, 0, 0, "R1");
    issue(0, 0, '0, 2'b00, 0, 0, "R1");
    issue(0, 0, a, 2'b11, 1, 0, "R12");
    a = rand_addr();                                     // R7 byte masks
    issue(0, 1, a, 2'b10, 1, 0, "");
    issue(0, 0, '0, 2'b00, 0, 0, "");
    issue(0, 0, '0, 2'b00, 0, 0, "");
    issue(0, 0, a, 2'b11, 1, 0, "R7");
    issue(0, 1, a, 2'b11, 1, 0, "");
    issue(0, 0, '0, 2'b00, 0, 0, "");
    issue(0, 0, '0, 2'b00, 0, 0, "");
    issue(0, 0, a, 2'b11, 1, 0, "R7");
    a = rand_addr();                                     // R11 pending-write bypass
    issue(0, 1, a, 2'b01, 1, 0, "");
    issue(0, 0, a, 2'b11, 1, 0, "R11");
    issue(0, 1, a, 2'b10, 1, 0, "");
    issue(0, 0, a, 2'b11, 1, 0, "R11");
    a = {rand_addr() >> 2, 2'b10};                       // R8/R9 wrapping read burst
    issue(0, 0, a, 2'b11, 1, 0, i ? "R9" : "R8");
    for (int k = 0; k < 5; k++) issue(1, 0, '0, 2'b11, 1, 0, i ? "R9" : "R8");
    a = {a[AW-1:2], 2'b01};                              // R10 write burst, we/ce toggled
    issue(0, 1, a, 2'b00, 1, 0, "");
    for (int k = 0; k < 3; k++) issue(1, 0, rand_addr(), 2'b00, k[0], 0, "R10");
    issue(0, 0, a, 2'b11, 1, 0, "R10");
    for (int k = 0; k < 3; k++) issue(1, 1, rand_addr(), 2'b00, 0, 0, "R10");
    probe = 1'b1;
    last_a = rand_addr();
    for (int n = 0; n < 600; n++) begin
      int r;
      bit oe;
      r  = $urandom % 100;
      oe = ($urandom % 20 == 0);
      if (r < 10) issue(0, $urandom % 2, rand_addr(), 2'($urandom), 0, oe, "");
      else if (r < 40) issue(1, $urandom % 2, rand_addr(), 2'($urandom), $urandom % 2, oe, "");
      else begin
        if ($urandom % 2) last_a = rand_addr();
        issue(0, $urandom % 2, last_a, 2'($urandom), 1, oe, "");
      end
    end
    probe = 1'b0;
    for (int k = 0; k < 3; k++) issue(0, 0, '0, 2'b11, 0, 0, "R1");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5a17));
    rst_n = 1'b0;
    run_phase(0, 0, 1);
    run_phase(1, 1, 0);
    run_phase(1, 0, 0);
    run_phase(0, 1, 0);
    finish_run();
  end

endmodule